// File: doc/BRIEF.md
# Dual-Oversampling UART Baud Generator

This block derives the timing strobes for a UART from a fixed system clock. A 16-bit divisor is loaded one byte at a time through two write strobes. A prescale counter divides the clock by that divisor and produces `sampleTick`, a single-cycle pulse at the receive sampling rate. An oversample counter then divides the sample ticks by 16 or by 13 and produces `bitTick`, one pulse per serial bit.

The oversampling factor can be changed at runtime through `modeThirteen`. With 13x oversampling, the same clock reaches baud rates that a fixed 16x divider cannot reach exactly. For example, a 48 MHz clock with 13x oversampling and divisors 8, 4, 2 and 1 gives roughly 461.5 k, 923 k, 1.846 M and 3.692 Mbaud. With 16x oversampling, a divisor of 10000 gives exactly 300 baud and a divisor of 26 gives about 115.38 kbaud.

A divisor of zero stops the generator and holds both counters at zero.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both `sampleTick` and `bitTick` are low, and they stay low until a nonzero divisor is loaded.
- R2: The divisor is {high byte, low byte}. `wrHi` loads bits 15:8 and `wrLo` loads bits 7:0 from `wrData` on the clock edge. For a nonzero divisor N, `sampleTick` is a one-cycle pulse that repeats every N clock cycles.
- R3: With a divisor of 1, `sampleTick` is high on every clock cycle.
- R4: While the divisor is zero, neither tick ever asserts and both counters are held at zero. After a nonzero divisor N is then loaded, the first `bitTick` arrives on the 16th (or 13th) sample tick.
- R5: Writing either divisor byte restarts the prescaler. If the new divisor N is greater than 1, `sampleTick` is low in the cycle after the write edge, first asserts in the N-th cycle after that edge, and then repeats every N cycles. The oversample count is not disturbed by the write.
- R6: With `modeThirteen` = 0, `bitTick` asserts together with every 16th `sampleTick`.
- R7: With `modeThirteen` = 1, `bitTick` asserts together with every 13th `sampleTick`.
- R8: A change of `modeThirteen` clears the oversample count. `bitTick` is low in the cycle of the change, and the next `bitTick` falls on the 16th (or 13th) sample tick after it.
- R9: `bitTick` is never high unless `sampleTick` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrHi | input | 1 | Write strobe for divisor bits 15:8 |
| wrLo | input | 1 | Write strobe for divisor bits 7:0 |
| wrData | input | 8 | Byte written by either strobe |
| modeThirteen | input | 1 | 0 selects 16x oversampling, 1 selects 13x |
| sampleTick | output | 1 | One-cycle pulse at the divided sample rate |
| bitTick | output | 1 | One-cycle pulse once per 16 or 13 sample ticks |

## Verification
The properties assume that `modeThirteen` and the write strobes are synchronous to `clk` and free of unknown values once reset is released. They also assume that a change of mode is a deliberate event, not a glitch, since every change restarts the bit phase. The stimulus drives all inputs on the falling edge. It moves the mode only while the divisor is zero or between sample ticks, and it writes the high byte before the low byte so that a half-written divisor never lasts beyond a single cycle.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes from the control side to the counting datapath.
  typedef struct packed {
    logic run;        // divisor is nonzero
    logic reloadPre;  // restart the prescale counter
    logic clearOvs;   // restart the oversample counter
  } baudCtl_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int LANES = 2,
  localparam int DIV_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              modeThirteen,
  output logic [DIV_W-1:0]  divisor,
  output baudCtl_t          ctl
);
  logic [LANES-1:0]             laneWr;
  logic [LANES-1:0][BYTE_W-1:0] laneQ;
  logic                         modeQ;

  assign laneWr = {wrHi, wrLo};

  // Byte lanes of the divisor; lane 1 is the high byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneQ <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (laneWr[i]) laneQ[i] <= wrData;
      end
    end
  end

  // Last sampled mode, used to spot a change.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= modeThirteen;
  end

  assign divisor       = laneQ;
  assign ctl.run       = |laneQ;
  assign ctl.reloadPre = |laneWr;
  assign ctl.clearOvs  = modeThirteen ^ modeQ;
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int OVS_STD = 16,
  parameter int OVS_ALT = 13,
  localparam int OVS_W  = $clog2(OVS_STD)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             modeThirteen,
  input  baudCtl_t         ctl,
  output logic             sampleTick,
  output logic             bitTick
);
  localparam logic [OVS_W-1:0] LAST_STD = OVS_W'(OVS_STD - 1);
  localparam logic [OVS_W-1:0] LAST_ALT = OVS_W'(OVS_ALT - 1);

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divLast;
  logic             preHit;
  logic [OVS_W-1:0] ovsCnt;
  logic [OVS_W-1:0] ovsLast;
  logic             ovsWrap;

  // Prescaler: counts 0 .. divisor-1 and fires on the last value.
  assign divLast = divisor - DIV_W'(1);
  assign preHit  = ctl.run && (preCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   preCnt <= '0;
    else if (!ctl.run || ctl.reloadPre || preHit) preCnt <= '0;
    else                                         preCnt <= preCnt + DIV_W'(1);
  end

  // Oversample counter: advances on each sample tick.
  assign ovsLast = modeThirteen ? LAST_ALT : LAST_STD;
  assign ovsWrap = preHit && (ovsCnt == ovsLast) && !ctl.clearOvs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        ovsCnt <= '0;
    else if (!ctl.run || ctl.clearOvs) ovsCnt <= '0;
    else if (preHit)                  ovsCnt <= ovsWrap ? '0 : ovsCnt + OVS_W'(1);
  end

  assign sampleTick = preHit;
  assign bitTick    = ovsWrap;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int OVS_STD = 16,
  parameter int OVS_ALT = 13,
  localparam int DIV_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              modeThirteen,
  output logic              sampleTick,
  output logic              bitTick
);
  logic [DIV_W-1:0] divisor;
  baudCtl_t         ctl;

  baud_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrHi         (wrHi),
    .wrLo         (wrLo),
    .wrData       (wrData),
    .modeThirteen (modeThirteen),
    .divisor      (divisor),
    .ctl          (ctl)
  );

  baud_datapath #(.DIV_W(DIV_W), .OVS_STD(OVS_STD), .OVS_ALT(OVS_ALT)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .divisor      (divisor),
    .modeThirteen (modeThirteen),
    .ctl          (ctl),
    .sampleTick   (sampleTick),
    .bitTick      (bitTick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int BYTE_W  = 8,
  parameter int OVS_STD = 16,
  parameter int OVS_ALT = 13,
  localparam int DIV_W  = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrHi,
  input logic              wrLo,
  input logic [BYTE_W-1:0] wrData,
  input logic              modeThirteen,
  input logic              sampleTick,
  input logic              bitTick
);
  logic [BYTE_W-1:0] hiS, loS;
  logic [DIV_W-1:0]  shadowDiv, nextDiv;
  logic              modePrev, modeChanged;
  logic [7:0]        ovsSeen;
  logic [7:0]        ovsLast;

  assign shadowDiv   = {hiS, loS};
  assign nextDiv     = {wrHi ? wrData : hiS, wrLo ? wrData : loS};
  assign modeChanged = modeThirteen != modePrev;
  assign ovsLast     = modeThirteen ? 8'(OVS_ALT - 1) : 8'(OVS_STD - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiS <= '0;
      loS <= '0;
      modePrev <= 1'b0;
      ovsSeen <= '0;
    end else begin
      if (wrHi) hiS <= wrData;
      if (wrLo) loS <= wrData;
      modePrev <= modeThirteen;
      if (shadowDiv == '0 || modeChanged) ovsSeen <= '0;
      else if (sampleTick)               ovsSeen <= bitTick ? 8'd0 : ovsSeen + 8'd1;
    end
  end

  // R9
  bit_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  // R4
  zero_div_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowDiv == '0) |-> (!sampleTick && !bitTick));

  // R3
  unit_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowDiv == DIV_W'(1)) |-> sampleTick);

  // R5
  reload_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wrHi || wrLo) && nextDiv != '0 && nextDiv != DIV_W'(1)) |=> !sampleTick);

  // R6 R7
  ovs_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (ovsSeen == ovsLast));

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> !bitTick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.BYTE_W(BYTE_W), .OVS_STD(OVS_STD), .OVS_ALT(OVS_ALT)) uChk (.*);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrHi = 1'b0;
  logic       wrLo = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       modeThirteen = 1'b0;
  logic       sampleTick, bitTick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam int NVEC = 6;
  localparam int VEC_DIV  [NVEC] = '{1, 2, 3, 13, 26, 258};
  localparam bit VEC_MODE [NVEC] = '{0, 1, 0, 1, 1, 0};

  baud_tick_gen uut (
    .clk(clk), .rstN(rstN), .wrHi(wrHi), .wrLo(wrLo), .wrData(wrData),
    .modeThirteen(modeThirteen), .sampleTick(sampleTick), .bitTick(bitTick)
  );

  always #5 clk = ~clk;

  // Check outputs each cycle up to lastCyc. Sample ticks fall where
  // (cyc - sBase) is a multiple of n; bit ticks where (cyc - bBase) is a multiple of bPer.
  task automatic observe(input int lastCyc, input int sBase, input int n,
                         input int bBase, input int bPer, input string tag);
    int  bad = 0;
    int  badCyc = 0;
    logic es, eb, aS, aB, xS, xB;
    while (cyc <= lastCyc) begin
      #1;
      es = (cyc > sBase) && (((cyc - sBase) % n) == 0);
      eb = es && (cyc > bBase) && (((cyc - bBase) % bPer) == 0);
      if (sampleTick !== es || bitTick !== eb) begin
        if (bad == 0) begin
          badCyc = cyc; aS = sampleTick; aB = bitTick; xS = es; xB = eb;
        end
        bad++;
      end
      @(negedge clk);
      cyc++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: cycle %0d actual sampleTick=%b bitTick=%b expected %b %b (%0d bad cycles)",
               tag, badCyc, aS, aB, xS, xB, bad);
    end
  endtask

  // Zero the divisor, set the mode, then load hi and lo; cyc=1 is the cycle after the lo write.
  task automatic writeDiv(input int div, input bit mode);
    @(negedge clk); wrHi = 1'b1; wrData = 8'h00;
    @(negedge clk); wrHi = 1'b0; wrLo = 1'b1;
    @(negedge clk); wrLo = 1'b0; modeThirteen = mode;
    @(negedge clk);
    @(negedge clk); wrHi = 1'b1; wrData = 8'((div >> 8) & 255);
    @(negedge clk); wrHi = 1'b0; wrLo = 1'b1; wrData = 8'(div & 255);
    @(negedge clk); wrLo = 1'b0;
    cyc = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 200000 cycles without finishing, expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs quiet through and after reset
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc = 1;
    observe(20, 1000000, 1, 0, 1, "R1 reset quiet");

    // Table walk: R2 period, R3 divisor one, R6/R7 bit ratio, R9 bit only with sample
    for (int v = 0; v < NVEC; v++) begin
      int k;
      k = VEC_MODE[v] ? 13 : 16;
      writeDiv(VEC_DIV[v], VEC_MODE[v]);
      observe(2 * k * VEC_DIV[v], 0, VEC_DIV[v], 0, VEC_DIV[v] * k,
              $sformatf("R2 R9 %s vec%0d div=%0d",
                        VEC_DIV[v] == 1 ? "R3" : (VEC_MODE[v] ? "R7" : "R6"), v, VEC_DIV[v]));
    end

    // R5: rewrite low byte mid-run; prescaler restarts, oversample count kept
    writeDiv(6, 1'b0);
    observe(8, 0, 6, 0, 96, "R2 before rewrite");
    wrLo = 1'b1; wrData = 8'd4;
    observe(9, 0, 6, 0, 96, "R5 write cycle");
    wrLo = 1'b0;
    observe(89, 9, 4, 5, 64, "R5 restart");

    // R4: zero divisor silences everything
    wrLo = 1'b1; wrData = 8'd0;
    @(negedge clk); wrLo = 1'b0;
    cyc = 1;
    observe(200, 1000000, 1, 0, 1, "R4 zero quiet");
    writeDiv(5, 1'b0);
    observe(160, 0, 5, 0, 80, "R4 counters held at zero");

    // R8: switch 16x -> 13x after five sample ticks
    writeDiv(4, 1'b0);
    observe(21, 0, 4, 0, 64, "R6 before switch");
    modeThirteen = 1'b1;
    observe(124, 0, 4, 20, 52, "R8 switch to 13x");

    // R8: switch back 13x -> 16x
    modeThirteen = 1'b0;
    observe(226, 0, 4, 124, 64, "R8 switch to 16x");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule